// File: doc/BRIEF.md
# Refresh Scheduler with Postponement Budget

This block decides when a dynamic memory of 4096 rows needs an AUTO REFRESH so that every row is refreshed within 64 ms. A free-running timer expires once per refresh interval (about 15.6 µs). Each expiry adds one unit to a refresh debt. A command sequencer services the debt whenever it has a gap in user traffic. The sequencer reports each refresh it has issued with a one-cycle done pulse.

The debt may grow to eight before servicing becomes mandatory. At that level an urgent flag tells the sequencer to put refreshes ahead of user traffic. This keeps the longest gap between two refreshes within eight intervals.

After every refresh, and after the memory leaves self refresh, a lockout output stays high for the refresh cycle time rounded up to whole clocks. The sequencer issues no command while it is high.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, and on the first cycle after it, the request, urgent and lockout outputs are all low.
- R2: The interval length is INTERVAL = floor(CLK_KHZ × REFI_NS / 10^6) clocks (781 with the defaults). The first request rises after exactly INTERVAL rising edges following reset release. Every further INTERVAL edges adds one to the debt.
- R3: The request output is high exactly when the debt is nonzero.
- R4: The urgent output is high exactly when the debt equals MAX_DEBT (8).
- R5: The debt never exceeds MAX_DEBT. An expiry at that level is dropped, so a single done pulse afterwards leaves the debt at MAX_DEBT − 1 and clears urgent.
- R6: A done pulse lowers the debt by one. A done pulse while the debt is zero has no effect, and the request stays low.
- R7: With a nonzero debt, a done pulse in the same cycle as a timer expiry leaves the debt unchanged.
- R8: After a done pulse, the lockout output is high for exactly TRFC_CYC = ceil(CLK_KHZ × TRFC_NS / 10^6) cycles (3 with the defaults), then low.
- R9: A self-refresh-exit pulse starts the same TRFC_CYC lockout. Any start pulse during a lockout restarts the full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_done_i | input | 1 | One-cycle pulse: the sequencer issued a refresh |
| sr_exit_i | input | 1 | One-cycle pulse: the memory left self refresh |
| ref_req_o | output | 1 | Refresh debt is pending |
| ref_urgent_o | output | 1 | Debt at its limit; refresh must preempt traffic |
| busy_o | output | 1 | Refresh-cycle lockout; no command allowed |

## Verification
The hardest case to reach is a done pulse in the very cycle the interval timer expires while the debt is saturated. Saturation takes eight full intervals, and the coincidence must then be hit on one exact edge. The bench's behavioural model keeps its own interval count. It waits until the debt is at the limit and the model's count is one edge from expiry, then places the done pulse on that edge. Restarted lockouts are produced by a second self-refresh-exit pulse issued while the first window is still open.

// File: rtl/refresh_pkg.sv
`timescale 1ns/1ps
package refresh_pkg;
  // clocks per refresh interval, rounded down so refreshes are never late
  function automatic int unsigned interval_cycles(input int unsigned khz, input int unsigned ns);
    longint unsigned prod;
    prod = longint'(khz) * longint'(ns);
    return int'(prod / 64'd1000000);
  endfunction

  // clocks covering a minimum delay, rounded up
  function automatic int unsigned delay_cycles(input int unsigned khz, input int unsigned ns);
    longint unsigned prod;
    prod = longint'(khz) * longint'(ns);
    return int'((prod + 64'd999999) / 64'd1000000);
  endfunction
endpackage

// File: rtl/refi_timer.sv
`timescale 1ns/1ps
module refi_timer #(
  parameter int unsigned INTERVAL = 781
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/refresh_debt.sv
`timescale 1ns/1ps
module refresh_debt #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] debt_o,
  output logic          pending_o,
  output logic          urgent_o
);
  localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q, debt_d;
  logic          room, take;

  assign room = (debt_q != TOP);
  assign take = dec_i && (debt_q != '0);

  always_comb begin
    debt_d = debt_q;
    unique case ({inc_i, take})
      2'b10:   if (room) debt_d = debt_q + 1'b1;
      2'b01:   debt_d = debt_q - 1'b1;
      default: debt_d = debt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assign debt_o    = debt_q;
  assign pending_o = (debt_q != '0);
  assign urgent_o  = !room;
endmodule

// File: rtl/rfc_lockout.sv
`timescale 1ns/1ps
module rfc_lockout #(
  parameter int unsigned TRFC_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned RW = $clog2(TRFC_CYC + 1);
  localparam logic [RW-1:0] LOAD = RW'(TRFC_CYC);

  logic [RW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)             left <= '0;
    else if (start_i)       left <= LOAD;
    else if (left != '0)    left <= left - 1'b1;
  end

  assign busy_o = (left != '0);
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched #(
  parameter int unsigned CLK_KHZ  = 50000,
  parameter int unsigned REFI_NS  = 15625,
  parameter int unsigned TRFC_NS  = 60,
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done_i,
  input  logic sr_exit_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic busy_o
);
  localparam int unsigned INTERVAL = refresh_pkg::interval_cycles(CLK_KHZ, REFI_NS);
  localparam int unsigned TRFC_CYC = refresh_pkg::delay_cycles(CLK_KHZ, TRFC_NS);
  localparam int unsigned DEBT_W   = $clog2(MAX_DEBT + 1);

  // named internal events, observed by the bound checker
  logic              expiry_tick;
  logic              lockout_start;
  logic [DEBT_W-1:0] debt_level;

  assign lockout_start = ref_done_i | sr_exit_i;

  refi_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (expiry_tick)
  );

  refresh_debt #(.MAX_DEBT(MAX_DEBT), .DW(DEBT_W)) u_debt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (expiry_tick),
    .dec_i     (ref_done_i),
    .debt_o    (debt_level),
    .pending_o (ref_req_o),
    .urgent_o  (ref_urgent_o)
  );

  rfc_lockout #(.TRFC_CYC(TRFC_CYC)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (lockout_start),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
  parameter int unsigned MAX_DEBT = 8,
  parameter int unsigned DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          done,
  input logic          sr_exit,
  input logic [DW-1:0] debt,
  input logic          req,
  input logic          urgent,
  input logic          busy
);
  AST_DEBT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DW'(MAX_DEBT)); // R5
  AST_TICK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !done && debt != DW'(MAX_DEBT)) |=> (debt == DW'($past(debt) + 1))); // R2
  AST_DONE_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick && debt != '0) |=> (debt == DW'($past(debt) - 1))); // R6
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick && debt == '0) |=> !req); // R6
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && tick && debt != '0) |=> $stable(debt)); // R7
  AST_URGENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !done) |=> urgent); // R5
  AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req); // R4
  AST_LOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (done || sr_exit) |=> busy); // R9
endmodule

bind refresh_sched refresh_sched_chk #(.MAX_DEBT(MAX_DEBT), .DW(DEBT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (expiry_tick),
  .done    (ref_done_i),
  .sr_exit (sr_exit_i),
  .debt    (debt_level),
  .req     (ref_req_o),
  .urgent  (ref_urgent_o),
  .busy    (busy_o)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  // independent restatement: clock in MHz, times in ns
  localparam int CLK_MHZ = 50;
  localparam int IVAL    = (CLK_MHZ * 15625) / 1000;        // floor -> 781
  localparam int LOCK    = (CLK_MHZ * 60 + 999) / 1000;     // ceil  -> 3
  localparam int LIMIT   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_done_i = 1'b0;
  logic sr_exit_i = 1'b0;
  logic ref_req_o, ref_urgent_o, busy_o;

  int checks = 0;
  int errors = 0;
  int m_phase = 0;
  int m_debt = 0;
  int m_lock = 0;

  always #10 clk = ~clk;

  refresh_sched u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_done_i   (ref_done_i),
    .sr_exit_i    (sr_exit_i),
    .ref_req_o    (ref_req_o),
    .ref_urgent_o (ref_urgent_o),
    .busy_o       (busy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one clock: drive at negedge, model steps on posedge, compare at next negedge
  task automatic step(input bit d, input bit s);
    bit expiry;
    ref_done_i = d;
    sr_exit_i  = s;
    @(posedge clk);
    expiry  = (m_phase == IVAL - 1);
    m_phase = expiry ? 0 : m_phase + 1;
    if (expiry && !(d && m_debt > 0)) begin
      if (m_debt < LIMIT) m_debt++;
    end else if (!expiry && d && m_debt > 0) begin
      m_debt--;
    end
    if (d || s) m_lock = LOCK;
    else if (m_lock > 0) m_lock--;
    @(negedge clk);
    ref_done_i = 1'b0;
    sr_exit_i  = 1'b0;
    chk("R3", ref_req_o, m_debt > 0);
    chk("R4", ref_urgent_o, m_debt == LIMIT);
    chk("R8", busy_o, m_lock > 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", ref_req_o, 0);
    chk("R1", ref_urgent_o, 0);
    chk("R1", busy_o, 0);
    rst_n = 1'b1;

    // R2: first expiry after exactly IVAL edges
    idle(IVAL - 1);
    chk("R2", ref_req_o, 0);
    step(1'b0, 1'b0);
    chk("R2", ref_req_o, 1);

    // R6 + R8: service it, lockout of exactly LOCK cycles
    step(1'b1, 1'b0);
    chk("R6", ref_req_o, 0);
    chk("R8", busy_o, 1);
    idle(LOCK - 1);
    chk("R8", busy_o, 1);
    idle(1);
    chk("R8", busy_o, 0);

    // R6: done with zero debt is ignored
    step(1'b1, 1'b0);
    chk("R6", ref_req_o, 0);
    idle(LOCK);

    // R4/R5: accumulate past the limit
    idle(IVAL * (LIMIT + 2));
    chk("R4", ref_urgent_o, 1);
    while (m_phase == IVAL - 1) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R5", ref_urgent_o, 0);
    chk("R5", ref_req_o, 1);

    // R7: done coinciding with expiry at the limit
    while (m_debt != LIMIT) step(1'b0, 1'b0);
    while (m_phase != IVAL - 1) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R7", ref_urgent_o, 1);
    idle(LOCK + 1);

    // R9: self-refresh exit lockout and restart
    step(1'b0, 1'b1);
    chk("R9", busy_o, 1);
    idle(LOCK - 2);
    step(1'b0, 1'b1);
    idle(LOCK - 1);
    chk("R9", busy_o, 1);
    idle(1);
    chk("R9", busy_o, 0);

    // R6: drain the debt completely
    for (int k = 0; k < LIMIT + 2; k++) begin
      step(1'b1, 1'b0);
      idle(LOCK);
    end
    chk("R6", ref_req_o, m_debt > 0);
    chk("R6", m_debt, 0);
    summary();
  end
endmodule